// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the control core of a synchronous, flow-through static memory with a built-in two-bit burst sequencer. On every rising clock edge it samples two address-status strobes (one on the processor side, one on the controller side), a burst step input, three chip selects, the write controls and the address. From these it decides whether the cycle deselects the part, begins a burst at an external address, steps the burst to its next address, or holds the burst at its current address to insert a wait state. Writes go into a behavioural array through per-lane write enables. Each lane is one data byte plus its parity bit.

Reads are flow-through. The address captured at an edge selects a word, and that word is driven onto the shared bidirectional data bus during the following clock cycle. The bus is driven only when the cycle was a selected read and output enable is low. The burst order is set by a static mode input. The low two address bits either count upward with wrap-around, or are XOR-ed with the burst count. A host uses the processor strobe for fast read starts. It uses the controller strobe for reads or writes at an external address, and for deselecting the part.

Top module: `sbsram_ctrl`

## Requirements
- R1: With `cpu_strobe_n` low and `sel_a_n` low, a read burst begins at `addr_in` on that edge and no lane is written, whatever the write controls are.
- R2: With `sel_a_n` high, `cpu_strobe_n` is ignored. A low `ctl_strobe_n` then deselects the part (bus high impedance). With both strobes effectively high, an active burst steps or holds and an idle part stays idle.
- R3: `sel_b` (active high) and `sel_c_n` (active low) are sampled only on edges where a strobe starts a cycle. Changing them during step or hold cycles has no effect.
- R4: `wr_all_n` low writes every lane of the addressed word, whatever `wr_lane_en_n` and `lane_sel_n` are.
- R5: With `wr_all_n` high and `wr_lane_en_n` low, lane i is written when `lane_sel_n[i]` is low. Lane i is bits [9i+8:9i] of the word, and bit 9i+8 is that lane's parity bit.
- R6: A cycle with no lane selected for write is a read. This covers `wr_all_n` and `wr_lane_en_n` both high, and `wr_lane_en_n` low with every `lane_sel_n` bit high.
- R7: With both strobes high on an active burst and `step_n` low, the burst moves to its next address. With `xor_order`=0 the low two bits are (start+k) mod 4. With `xor_order`=1 they are start XOR k. Here k is the step count since the burst began, and the upper bits do not change.
- R8: With both strobes high on an active burst and `step_n` high, the address is held. A read or write then targets the same word again.
- R9: After a deselect edge the bus is high impedance. During a read, `out_en_n` high forces high impedance, and the bus is never driven after a write edge.
- R10: After a read edge, the addressed word appears on `dq` in the same clock period, before the next rising edge.
- R11: Synchronous reset leaves the part deselected with the bus at high impedance. Step and hold requests then have no effect until a strobe selects the part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| xor_order | input | 1 | Burst order: 0 wrap-around count, 1 XOR order; static during a burst |
| addr_in | input | ADDR_W | External word address |
| cpu_strobe_n | input | 1 | Processor-side address strobe, active low, read-only start |
| ctl_strobe_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst step request, active low |
| sel_a_n | input | 1 | Chip select, active low, also masks the processor strobe |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lane_en_n | input | 1 | Per-lane write enable gate, active low |
| lane_sel_n | input | LANES | Per-lane write strobes, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq | inout | LANES*LANE_W | Shared data bus |

## Verification
The bench builds the block with a 6-bit address (64 words) and the default four 9-bit lanes. With only 64 words, random addresses often hit words written earlier, so partial lane writes and read-after-write through holds and bursts are checked against real stored data. The wrap of the 2-bit burst sequence is reached in a few cycles in both orders. Every word is first filled with a distinct value, so an address-order error shows up as a wrong data word on the bus.

// File: rtl/sbsram_pkg.sv
`timescale 1ns/1ps
package sbsram_pkg;

  // Cycle kinds decided on each rising edge.
  typedef enum logic [2:0] {
    CYC_IDLE      = 3'd0,  // not selected, nothing happens
    CYC_DESEL     = 3'd1,  // strobe with chip selects false
    CYC_BEGIN_CPU = 3'd2,  // processor strobe: read at external address
    CYC_BEGIN_CTL = 3'd3,  // controller strobe: read or write at external address
    CYC_NEXT      = 3'd4,  // step burst to next address
    CYC_HOLD      = 3'd5   // keep burst at current address
  } cyc_e;

  localparam int BURST_BITS = 2;

  // Low address bits for burst position k, started at 'start'.
  function automatic logic [BURST_BITS-1:0] burst_low(
    input logic [BURST_BITS-1:0] start,
    input logic [BURST_BITS-1:0] k,
    input logic                  xor_mode
  );
    return xor_mode ? (start ^ k) : (start + k);
  endfunction

endpackage

// File: rtl/sbsram_decode.sv
`timescale 1ns/1ps
module sbsram_decode
  import sbsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             cpu_strobe_n,
  input  logic             ctl_strobe_n,
  input  logic             step_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             wr_all_n,
  input  logic             wr_lane_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             active,
  output cyc_e             cyc,
  output logic [LANES-1:0] lane_we,
  output logic             is_read
);

  logic             selected;
  logic             cpu_go;
  logic             can_write;
  logic [LANES-1:0] want;

  always_comb begin
    selected = !sel_a_n && sel_b && !sel_c_n;
    // the active-low primary select masks the processor strobe
    cpu_go   = !cpu_strobe_n && !sel_a_n;

    if (!wr_all_n)          want = '1;
    else if (!wr_lane_en_n) want = ~lane_sel_n;
    else                    want = '0;

    if (cpu_go)             cyc = selected ? CYC_BEGIN_CPU : CYC_DESEL;
    else if (!ctl_strobe_n) cyc = selected ? CYC_BEGIN_CTL : CYC_DESEL;
    else if (active)        cyc = step_n ? CYC_HOLD : CYC_NEXT;
    else                    cyc = CYC_IDLE;

    can_write = (cyc == CYC_BEGIN_CTL) || (cyc == CYC_NEXT) || (cyc == CYC_HOLD);
    lane_we   = can_write ? want : '0;
    is_read   = (cyc == CYC_BEGIN_CPU) || (can_write && (want == '0));
  end

endmodule

// File: rtl/sbsram_burst.sv
`timescale 1ns/1ps
module sbsram_burst
  import sbsram_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  step,
  input  logic [BURST_BITS-1:0] start,
  input  logic                  xor_mode,
  output logic [BURST_BITS-1:0] cur_low,
  output logic [BURST_BITS-1:0] nxt_low
);

  logic [BURST_BITS-1:0] start_q;
  logic [BURST_BITS-1:0] k_q;
  logic [BURST_BITS-1:0] k_inc;

  assign k_inc = k_q + BURST_BITS'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      k_q     <= '0;
    end else if (load) begin
      start_q <= start;
      k_q     <= '0;
    end else if (step) begin
      k_q     <= k_inc;
    end
  end

  assign cur_low = burst_low(start_q, k_q, xor_mode);
  assign nxt_low = burst_low(start_q, k_inc, xor_mode);

endmodule

// File: rtl/sbsram_array.sv
`timescale 1ns/1ps
module sbsram_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          we,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [LANES*LANE_W-1:0]   rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  // One bank per lane, so each lane (data byte plus parity) has its own enable.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) bank[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
  end

endmodule

// File: rtl/sbsram_ctrl.sv
`timescale 1ns/1ps
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    xor_order,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic                    cpu_strobe_n,
  input  logic                    ctl_strobe_n,
  input  logic                    step_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    wr_all_n,
  input  logic                    wr_lane_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    out_en_n,
  inout  wire  [LANES*LANE_W-1:0] dq
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int HI_W   = ADDR_W - BURST_BITS;

  cyc_e                  cyc;
  logic [LANES-1:0]      lane_we;
  logic [LANES-1:0]      mem_we;
  logic                  is_read;
  logic                  act_q;
  logic                  rd_q;
  logic [HI_W-1:0]       hi_q;
  logic [BURST_BITS-1:0] cur_low;
  logic [BURST_BITS-1:0] nxt_low;
  logic                  begin_cyc;
  logic [ADDR_W-1:0]     eff_addr;
  logic [ADDR_W-1:0]     addr_q;
  logic [DATA_W-1:0]     rdata;
  logic                  drv_en;

  sbsram_decode #(.LANES(LANES)) u_decode (
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .step_n       (step_n),
    .sel_a_n      (sel_a_n),
    .sel_b        (sel_b),
    .sel_c_n      (sel_c_n),
    .wr_all_n     (wr_all_n),
    .wr_lane_en_n (wr_lane_en_n),
    .lane_sel_n   (lane_sel_n),
    .active       (act_q),
    .cyc          (cyc),
    .lane_we      (lane_we),
    .is_read      (is_read)
  );

  assign begin_cyc = (cyc == CYC_BEGIN_CPU) || (cyc == CYC_BEGIN_CTL);

  sbsram_burst u_burst (
    .clk      (clk),
    .rst      (rst),
    .load     (begin_cyc),
    .step     (cyc == CYC_NEXT),
    .start    (addr_in[BURST_BITS-1:0]),
    .xor_mode (xor_order),
    .cur_low  (cur_low),
    .nxt_low  (nxt_low)
  );

  // Address this edge operates on: external, stepped or held.
  always_comb begin
    if (begin_cyc)             eff_addr = addr_in;
    else if (cyc == CYC_NEXT)  eff_addr = {hi_q, nxt_low};
    else                       eff_addr = {hi_q, cur_low};
  end

  assign addr_q = {hi_q, cur_low};
  assign mem_we = rst ? '0 : lane_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      rd_q  <= 1'b0;
      hi_q  <= '0;
    end else begin
      unique case (cyc)
        CYC_BEGIN_CPU, CYC_BEGIN_CTL: begin
          act_q <= 1'b1;
          rd_q  <= is_read;
          hi_q  <= addr_in[ADDR_W-1:BURST_BITS];
        end
        CYC_NEXT, CYC_HOLD: rd_q <= is_read;
        CYC_DESEL: begin
          act_q <= 1'b0;
          rd_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  sbsram_array #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_array (
    .clk   (clk),
    .we    (mem_we),
    .waddr (eff_addr),
    .wdata (dq),
    .raddr (addr_q),
    .rdata (rdata)
  );

  // Flow-through read: registered address, unregistered data path.
  assign drv_en = rd_q && !out_en_n;
  assign dq     = drv_en ? rdata : {DATA_W{1'bz}};

  // R1: a processor-strobe start never writes
  a_r1_cpu_no_write: assert property (@(posedge clk) disable iff (rst)
    (!cpu_strobe_n && !sel_a_n) |-> (mem_we == '0));

  // R3: step/hold cycles keep the part selected whatever the secondary selects do
  a_r3_keep_active: assert property (@(posedge clk) disable iff (rst)
    (act_q && (cpu_strobe_n || sel_a_n) && ctl_strobe_n) |=> act_q);

  // R4: all-lane write enables every lane on a controller-strobe start
  a_r4_all_lanes: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_BEGIN_CTL && !wr_all_n) |-> ($countones(mem_we) == LANES));

  // R8: a hold keeps the burst address
  a_r8_hold_addr: assert property (@(posedge clk) disable iff (rst)
    (act_q && (cpu_strobe_n || sel_a_n) && ctl_strobe_n && step_n) |=> $stable(addr_q));

  // R2 / R9: controller strobe with primary select false leaves the bus undriven
  a_r9_desel_hiz: assert property (@(posedge clk) disable iff (rst)
    (!ctl_strobe_n && sel_a_n) |=> !drv_en);

  // R11: reset deselects
  a_r11_reset_idle: assert property (@(posedge clk)
    rst |=> (!act_q && !drv_en));

endmodule

// File: tb/tb_sbsram_ctrl.sv
`timescale 1ns/1ps
module tb_sbsram_ctrl;

  localparam int AW    = 6;
  localparam int LN    = 4;
  localparam int LW    = 9;
  localparam int DW    = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          xor_order = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          cpu_strobe_n = 1'b1, ctl_strobe_n = 1'b1, step_n = 1'b1;
  logic          sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
  logic          wr_all_n = 1'b1, wr_lane_en_n = 1'b1;
  logic [LN-1:0] lane_sel_n = '1;
  logic          out_en_n = 1'b0;
  logic [DW-1:0] tb_d = '0;
  logic          tb_den = 1'b0;
  wire  [DW-1:0] dq;

  assign dq = tb_den ? tb_d : {DW{1'bz}};

  always #10 clk = ~clk;

  sbsram_ctrl #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut (
    .clk(clk), .rst(rst), .xor_order(xor_order), .addr_in(addr_in),
    .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n), .step_n(step_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .lane_sel_n(lane_sel_n),
    .out_en_n(out_en_n), .dq(dq)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // Reference model state
  logic [DW-1:0]   mm [DEPTH];
  bit              m_act = 1'b0, m_rd = 1'b0;
  logic [AW-3:0]   m_hi = '0;
  logic [1:0]      m_st = '0, m_k = '0;

  function automatic logic [1:0] ord(input logic [1:0] s, input logic [1:0] k, input logic x);
    logic [1:0] r;
    if (x) r = s ^ k;
    else   r = 2'((int'(s) + int'(k)) % 4);
    return r;
  endfunction

  function automatic logic [DW-1:0] seed_word(input int i);
    logic [31:0] h;
    h = 32'(i) * 32'h9E37_79B1 + 32'h1357;
    return {4'(i), h};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: dq=%h expected %h", tag, act, exp);
    end
  endtask

  // One clock: model the edge from the currently driven inputs, then check dq.
  task automatic step(input string tag);
    logic [LN-1:0] wl;
    logic [AW-1:0] ea;
    logic [DW-1:0] exp;
    bit            sel, cpugo;
    string         t;
    wl    = !wr_all_n ? '1 : (!wr_lane_en_n ? ~lane_sel_n : '0);
    sel   = !sel_a_n && sel_b && !sel_c_n;
    cpugo = !cpu_strobe_n && !sel_a_n;
    t     = tag;
    ea    = '0;
    @(posedge clk);
    if (rst) begin
      m_act = 0; m_rd = 0; m_hi = '0; m_st = '0; m_k = '0;
      if (t == "") t = "R11";
    end else if (cpugo) begin
      if (sel) begin
        m_act = 1; m_rd = 1; m_hi = addr_in[AW-1:2]; m_st = addr_in[1:0]; m_k = '0;
        if (t == "") t = "R1";
      end else begin
        m_act = 0; m_rd = 0;
        if (t == "") t = "R9";
      end
    end else if (!ctl_strobe_n) begin
      if (sel) begin
        m_act = 1; m_hi = addr_in[AW-1:2]; m_st = addr_in[1:0]; m_k = '0;
        ea = addr_in;
        for (int l = 0; l < LN; l++) if (wl[l]) mm[ea][l*LW +: LW] = tb_d[l*LW +: LW];
        m_rd = (wl == '0);
        if (t == "") t = (wl == '0) ? "R10" : "R5";
      end else begin
        m_act = 0; m_rd = 0;
        if (t == "") t = "R9";
      end
    end else if (m_act) begin
      if (!step_n) m_k = m_k + 2'd1;
      ea = {m_hi, ord(m_st, m_k, xor_order)};
      for (int l = 0; l < LN; l++) if (wl[l]) mm[ea][l*LW +: LW] = tb_d[l*LW +: LW];
      m_rd = (wl == '0);
      if (t == "") t = step_n ? "R8" : "R7";
    end else begin
      if (t == "") t = "R2";
    end
    #1 tb_den = 1'b0;
    #1;
    if (m_rd && !out_en_n) exp = mm[{m_hi, ord(m_st, m_k, xor_order)}];
    else                   exp = {DW{1'bz}};
    check(dq === exp, t, dq, exp);
    @(negedge clk);
  endtask

  task automatic quiet();
    cpu_strobe_n = 1; ctl_strobe_n = 1; step_n = 1;
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    wr_all_n = 1; wr_lane_en_n = 1; lane_sel_n = '1;
    out_en_n = 0; tb_den = 0;
  endtask

  task automatic rand_cycle();
    bit wr;
    cpu_strobe_n = ($urandom % 100) >= 15;
    ctl_strobe_n = ($urandom % 100) >= 20;
    step_n       = ($urandom % 2) == 1;
    sel_a_n      = ($urandom % 100) >= 85;
    sel_b        = ($urandom % 100) < 90;
    sel_c_n      = ($urandom % 100) >= 90;
    wr_all_n     = ($urandom % 100) >= 10;
    wr_lane_en_n = ($urandom % 100) >= 40;
    lane_sel_n   = 4'($urandom);
    addr_in      = 6'($urandom);
    wr = !wr_all_n || (!wr_lane_en_n && lane_sel_n != '1);
    if (wr) begin
      out_en_n = 1; tb_den = 1; tb_d = {4'($urandom), 32'($urandom)};
    end else begin
      out_en_n = ($urandom % 5) == 0; tb_den = 0;
    end
  endtask

  initial begin
    void'($urandom(32'h00C0_FFEE));
    quiet();
    @(negedge clk);
    // R11: reset state
    rst = 1;
    step("R11");
    step("R11");
    rst = 0;
    step_n = 0;
    step("R11");   // step request while deselected: bus stays undriven
    quiet();

    // R4: fill every word with all-lane writes (lane controls deliberately off)
    for (int i = 0; i < DEPTH; i++) begin
      ctl_strobe_n = 0; addr_in = AW'(i); wr_all_n = 0; wr_lane_en_n = 1; lane_sel_n = '1;
      out_en_n = 1; tb_den = 1; tb_d = seed_word(i);
      step("R4");
    end
    quiet();

    // R1: processor start with write controls asserted is a read
    cpu_strobe_n = 0; addr_in = 6'd5; wr_all_n = 0; tb_den = 1; tb_d = '0;
    step("R1");
    quiet();
    // R5: write on the following edge, lanes 1 and 3 only (incl. parity bits)
    wr_lane_en_n = 0; lane_sel_n = 4'b0101; out_en_n = 1; tb_den = 1; tb_d = {DW{1'b1}};
    step("R5");
    quiet();
    step("R8");    // hold: reread merged word
    // R6: lane gate low but no lane selected is a read
    wr_lane_en_n = 0; lane_sel_n = '1;
    step("R6");
    quiet();
    // R9: output enable high during a read
    out_en_n = 1;
    step("R9");
    out_en_n = 0;
    step("R10");

    // R7: wrap-around order from low bits 2
    xor_order = 0;
    ctl_strobe_n = 0; addr_in = 6'd6;
    step("R7");
    quiet();
    step_n = 0;
    step("R7");
    sel_b = 0; sel_c_n = 1;           // R3: secondary selects ignored mid-burst
    step("R3");
    step("R3");
    sel_b = 1; sel_c_n = 0;
    step("R7");
    step("R7");
    quiet();

    // deselect then change order while idle
    ctl_strobe_n = 0; sel_b = 0;
    step("R9");
    quiet();
    xor_order = 1;
    ctl_strobe_n = 0; addr_in = 6'd9;
    step("R7");
    quiet();
    step_n = 0;
    step("R7");
    step("R7");
    step("R7");
    step("R7");
    quiet();

    // R2: primary select high blocks the processor strobe
    sel_a_n = 1; cpu_strobe_n = 0; addr_in = 6'd40;
    step("R2");    // active: acts as hold
    cpu_strobe_n = 1; ctl_strobe_n = 0;
    step("R2");    // controller strobe deselects
    ctl_strobe_n = 1; cpu_strobe_n = 0;
    step("R2");    // idle stays idle
    quiet();

    // Random phases, one per burst order
    for (int ph = 0; ph < 2; ph++) begin
      ctl_strobe_n = 0; sel_a_n = 1;
      step("R9");
      quiet();
      xor_order = ph[0];
      for (int n = 0; n < 1500; n++) begin
        rand_cycle();
        step("");
      end
      quiet();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule